// File: doc/BRIEF.md
# Configurable registered fan-out buffer

This block is a bank of clocked registers placed on the command and address path of a memory module. It sits between a controller and many memory devices. Every input channel is captured on the rising clock edge and driven out one cycle later. Two static configuration pins select the shape of the bank. In the wide shape, 25 channels pass straight through one to one. In the narrow shape, 14 channels are registered and each one drives two identical output copies. In the narrow shape, a second pin picks which part of the input bus feeds the 14 channels and which part of the primary output bus carries them.

Two gating inputs let the host freeze the data channels while no device is addressed. When both are high at a clock edge, the data channels keep their values. The clock-enable channel, the termination channel and the registered chip-select output keep loading. An asynchronous active-low reset clears everything at once and takes priority over the gating.

Logical channel numbering is used throughout. Channel 0 is the clock-enable channel, channel 1 is the on-die-termination channel, and the remaining channels carry data.

Top module: `fanout_regbuf`

## Requirements
- R1: With `cfg_narrow` = 0, `qa_out[i]` equals `din[i]` as sampled at the previous rising edge for all 25 bits, and `qb_out` is all zero.
- R2: With `cfg_narrow` = 1 and `cfg_alt_map` = 0, channel k (k = 0..13) is taken from `din[k]`. It drives both `qa_out[k]` and `qb_out[k]`, and `qa_out[24:14]` is zero.
- R3: With `cfg_narrow` = 1 and `cfg_alt_map` = 1, channel k is taken from `din[11+k]`. It drives both `qa_out[11+k]` and `qb_out[k]`, and `qa_out[10:0]` is zero.
- R4: Outputs change only at a rising clock edge. A change on `din` or on either configuration pin between edges leaves the outputs untouched until the next rising edge.
- R5: While `rst_n` is low, `qa_out`, `qb_out` and `cs_out` are all zero. This takes effect without waiting for a clock edge.
- R6: When `gate_cs` and `gate_en` are both 1 at a rising edge, every data channel (logical channel 2 and above) keeps its previous value.
- R7: Channels 0 and 1 load at every edge whatever the gating inputs are. `cs_out` always shows `gate_cs` from the previous edge.
- R8: When either gating input is 0, every channel loads. With `gate_en` held at 0, `gate_cs` only affects `cs_out`.
- R9: Reset overrides the gating. A reset taken while both gating inputs are high leaves the data channels at zero, and they stay at zero through later gated edges.
- R10: After reset is released with `din` all zero and the clock running, every output stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_narrow | input | 1 | 0: 25-channel one-to-one; 1: 14-channel with two copies |
| cfg_alt_map | input | 1 | Narrow mode only: 0 lower bus window, 1 upper bus window |
| din | input | 25 | Channel inputs |
| gate_cs | input | 1 | First gating input, also registered to cs_out |
| gate_en | input | 1 | Second gating input; tie to 0 to disable gating |
| qa_out | output | 25 | Primary registered outputs |
| qb_out | output | 14 | Second copy in narrow mode, zero in wide mode |
| cs_out | output | 1 | Registered gate_cs, never frozen |

## Verification
The gating freeze and the loading of the control channels fall on the same edge: while data channels hold, channels 0 and 1 and `cs_out` must still update. Random gating bits are mixed with random data, so frozen and live channels often change in the same cycle. Reset and gating also collide. The bench lowers reset between edges while both gating inputs are high and checks for zeros at once. It then releases reset with gating still high and nonzero data, and expects zero data channels beside freshly loaded control channels.

// File: rtl/fanout_regbuf_pkg.sv
// Shared types for the configurable registered fan-out buffer.
package fanout_regbuf_pkg;

    // Shape selection captured together with the data.
    typedef struct packed {
        logic narrow;   // 1: reduced channel count with duplicated outputs
        logic alt;      // 1: upper bus window in narrow shape
    } shape_t;

endpackage

// File: rtl/ffb_chan_select.sv
// Input channel steering.
// Picks which input bits feed the logical channels for the requested shape.
// Assumes WIDE_W >= NARROW_W; channels above NARROW_W read zero in narrow shape.
module ffb_chan_select
    import fanout_regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic [WIDE_W-1:0] din,
    input  shape_t            shape,
    output logic [WIDE_W-1:0] sel_chan
);
    localparam int HI_BASE = WIDE_W - NARROW_W;

    for (genvar i = 0; i < WIDE_W; i++) begin : g_sel
        if (i < NARROW_W) begin : g_shared
            // Shared channel: lower or upper window in narrow shape.
            always_comb begin
                if (shape.narrow && shape.alt) sel_chan[i] = din[HI_BASE + i];
                else                           sel_chan[i] = din[i];
            end
        end else begin : g_wide_only
            // Channel used only in the wide shape.
            always_comb sel_chan[i] = shape.narrow ? 1'b0 : din[i];
        end
    end

endmodule

// File: rtl/ffb_reg_bank.sv
// Channel register bank.
// The lowest CTRL_CH channels load every edge. The rest hold while hold_data is high.
// Assumes the asynchronous active-low reset dominates every other input.
module ffb_reg_bank #(
    parameter int WIDE_W  = 25,
    parameter int CTRL_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_data,
    input  logic [WIDE_W-1:0] sel_chan,
    output logic [WIDE_W-1:0] chan_q
);
    for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
        if (i < CTRL_CH) begin : g_ctrl
            // Control channel: captured at every edge, never frozen.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chan_q[i] <= 1'b0;
                else        chan_q[i] <= sel_chan[i];
            end
        end else begin : g_data
            // Data channel: captured unless the gating freezes it.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          chan_q[i] <= 1'b0;
                else if (!hold_data) chan_q[i] <= sel_chan[i];
            end
        end
    end

endmodule

// File: rtl/ffb_out_map.sv
// Output mapping.
// Places the registered channels on the primary bus and the duplicate bus for the captured shape.
// Assumes unused output bits must read zero.
module ffb_out_map
    import fanout_regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic [WIDE_W-1:0]   chan_q,
    input  shape_t              shape_q,
    output logic [WIDE_W-1:0]   qa_out,
    output logic [NARROW_W-1:0] qb_out
);
    localparam int HI_BASE = WIDE_W - NARROW_W;

    for (genvar i = 0; i < WIDE_W; i++) begin : g_qa
        logic lo_bit;
        logic hi_bit;
        if (i < NARROW_W) begin : g_lo
            assign lo_bit = chan_q[i];
        end else begin : g_lo_off
            assign lo_bit = 1'b0;
        end
        if (i >= HI_BASE) begin : g_hi
            assign hi_bit = chan_q[i - HI_BASE];
        end else begin : g_hi_off
            assign hi_bit = 1'b0;
        end
        // Primary bit: straight, lower window or upper window.
        always_comb begin
            if (!shape_q.narrow)  qa_out[i] = chan_q[i];
            else if (shape_q.alt) qa_out[i] = hi_bit;
            else                  qa_out[i] = lo_bit;
        end
    end

    for (genvar j = 0; j < NARROW_W; j++) begin : g_qb
        // Duplicate bit: live only in narrow shape.
        always_comb qb_out[j] = shape_q.narrow ? chan_q[j] : 1'b0;
    end

endmodule

// File: rtl/fanout_regbuf.sv
// Configurable registered fan-out buffer, top level.
// Steers inputs, registers channels with chip-select gating, maps outputs.
// Assumes configuration pins are quasi-static; they are registered with the data.
module fanout_regbuf
    import fanout_regbuf_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int CTRL_CH  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_narrow,
    input  logic                cfg_alt_map,
    input  logic [WIDE_W-1:0]   din,
    input  logic                gate_cs,
    input  logic                gate_en,
    output logic [WIDE_W-1:0]   qa_out,
    output logic [NARROW_W-1:0] qb_out,
    output logic                cs_out
);
    shape_t            shape_now;
    shape_t            shape_q;
    logic [WIDE_W-1:0] sel_chan;
    logic [WIDE_W-1:0] chan_q;
    logic              hold_data;

    assign shape_now = '{narrow: cfg_narrow, alt: cfg_alt_map};
    assign hold_data = gate_cs & gate_en;

    // Capture shape and chip-select together with the channels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shape_q <= '0;
            cs_out  <= 1'b0;
        end else begin
            shape_q <= shape_now;
            cs_out  <= gate_cs;
        end
    end

    ffb_chan_select #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_sel (
        .din      (din),
        .shape    (shape_now),
        .sel_chan (sel_chan)
    );

    ffb_reg_bank #(.WIDE_W(WIDE_W), .CTRL_CH(CTRL_CH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_data (hold_data),
        .sel_chan  (sel_chan),
        .chan_q    (chan_q)
    );

    ffb_out_map #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_map (
        .chan_q  (chan_q),
        .shape_q (shape_q),
        .qa_out  (qa_out),
        .qb_out  (qb_out)
    );

endmodule

// File: rtl/ffb_checker.sv
// Property checker for fanout_regbuf, attached by bind.
module ffb_checker #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14,
    parameter int CTRL_CH  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_narrow,
    input logic                cfg_alt_map,
    input logic                gate_cs,
    input logic                gate_en,
    input logic [WIDE_W-1:0]   sel_chan,
    input logic [WIDE_W-1:0]   chan_q,
    input logic [WIDE_W-1:0]   qa_out,
    input logic [NARROW_W-1:0] qb_out,
    input logic                cs_out
);
    localparam int HI_BASE = WIDE_W - NARROW_W;

    assert_wide_dup_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_narrow)) |-> (qb_out == '0));

    assert_lo_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_narrow) && !$past(cfg_alt_map))
        |-> (qa_out[WIDE_W-1:NARROW_W] == '0 && qb_out == qa_out[NARROW_W-1:0]));

    assert_hi_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_narrow) && $past(cfg_alt_map))
        |-> (qa_out[HI_BASE-1:0] == '0 && qb_out == qa_out[WIDE_W-1:HI_BASE]));

    assert_reset_clear_R5: assert property (@(posedge clk)
        (!$past(rst_n) && !rst_n) |-> (qa_out == '0 && qb_out == '0 && !cs_out));

    assert_gated_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cs && gate_en) |=> $stable(chan_q[WIDE_W-1:CTRL_CH]));

    assert_ctrl_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (chan_q[CTRL_CH-1:0] == $past(sel_chan[CTRL_CH-1:0])));

    assert_cs_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cs_out == $past(gate_cs)));

    assert_ungated_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_cs && gate_en) |=> (chan_q == $past(sel_chan)));

endmodule

bind fanout_regbuf ffb_checker #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CTRL_CH(CTRL_CH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_alt_map(cfg_alt_map),
    .gate_cs(gate_cs), .gate_en(gate_en), .sel_chan(sel_chan), .chan_q(chan_q),
    .qa_out(qa_out), .qb_out(qb_out), .cs_out(cs_out)
);

// File: tb/fanout_regbuf_test.sv
`timescale 1ns/1ps
module fanout_regbuf_test;
    localparam int W  = 25;
    localparam int N  = 14;
    localparam int HB = W - N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_narrow = 1'b0;
    logic         cfg_alt_map = 1'b0;
    logic [W-1:0] din = '0;
    logic         gate_cs = 1'b0;
    logic         gate_en = 1'b0;
    logic [W-1:0] qa_out;
    logic [N-1:0] qb_out;
    logic         cs_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [W-1:0] m_chan = '0;
    logic         m_nar = 1'b0;
    logic         m_alt = 1'b0;
    logic         m_cs = 1'b0;

    always #2 clk = ~clk;

    fanout_regbuf uut (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_alt_map(cfg_alt_map),
        .din(din), .gate_cs(gate_cs), .gate_en(gate_en),
        .qa_out(qa_out), .qb_out(qb_out), .cs_out(cs_out)
    );

    // Logical channel vector that the inputs present for a given shape (R1..R3).
    function automatic logic [W-1:0] chan_from(input logic [W-1:0] d, input logic nar, input logic alt);
        logic [W-1:0] r = '0;
        if (!nar) r = d;
        else if (!alt) r[N-1:0] = d[N-1:0];
        else r[N-1:0] = d[W-1:HB];
        return r;
    endfunction

    function automatic logic [W-1:0] exp_qa(input logic [W-1:0] c, input logic nar, input logic alt);
        logic [W-1:0] r = '0;
        if (!nar) r = c;
        else if (!alt) r[N-1:0] = c[N-1:0];
        else r[W-1:HB] = c[N-1:0];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_qb(input logic [W-1:0] c, input logic nar);
        return nar ? c[N-1:0] : '0;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " qa"}, qa_out, exp_qa(m_chan, m_nar, m_alt));
        check({tag, " qb"}, W'(qb_out), W'(exp_qb(m_chan, m_nar)));
        check({tag, " cs"}, W'(cs_out), W'(m_cs));
    endtask

    // One cycle from a falling edge: drive, R4 pre-edge check, edge, model, check.
    task automatic step(input logic [W-1:0] d, input logic nar, input logic alt,
                        input logic gc, input logic ge, input string tag);
        logic [W-1:0] s;
        din = d; cfg_narrow = nar; cfg_alt_map = alt; gate_cs = gc; gate_en = ge;
        #1;
        check("R4 no change between edges", qa_out, exp_qa(m_chan, m_nar, m_alt));
        @(posedge clk);
        if (rst_n) begin
            s = chan_from(d, nar, alt);
            if (gc && ge) m_chan[1:0] = s[1:0];   // R6/R7: data frozen, ctrl live
            else          m_chan = s;             // R8
            m_nar = nar; m_alt = alt; m_cs = gc;
        end
        @(negedge clk);
        #0.5;
        check_all(tag);
    endtask

    task automatic model_reset();
        m_chan = '0; m_nar = 1'b0; m_alt = 1'b0; m_cs = 1'b0;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] d;
        logic nar, alt, gc, ge;
        string tag;
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        #0.5;
        check_all("R5 reset state");
        rst_n = 1'b1;

        // R10: release with quiet inputs, outputs stay zero.
        for (int k = 0; k < 4; k++) step('0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 quiet after release");

        // Directed shapes.
        step(25'h1ABCDEF, 1'b0, 1'b0, 1'b0, 1'b0, "R1 wide");
        step(25'h0F0F0F0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 narrow lower");
        step(25'h1FF8000, 1'b1, 1'b1, 1'b0, 1'b0, "R3 narrow upper");
        step(25'h0000ABC, 1'b1, 1'b1, 1'b0, 1'b0, "R3 upper ignores low bits");

        // R7 with gating: data frozen, ctrl channels and cs live.
        step(25'h1555555, 1'b0, 1'b0, 1'b0, 1'b0, "R1 preload");
        step(25'h0AAAAAA, 1'b0, 1'b0, 1'b1, 1'b1, "R6 R7 gated");
        step(25'h0AAAAA9, 1'b0, 1'b0, 1'b1, 1'b1, "R6 R7 gated ctrl flip");
        step(25'h1234567, 1'b0, 1'b0, 1'b1, 1'b0, "R8 enable low loads");
        step(25'h0765432, 1'b0, 1'b0, 1'b0, 1'b1, "R8 cs low loads");

        // R9: reset between edges while gated, then gated release.
        din = 25'h1FFFFFF; gate_cs = 1'b1; gate_en = 1'b1;
        #0.5;
        rst_n = 1'b0;
        #0.5;
        model_reset();
        check_all("R5 R9 async clear while gated");
        @(negedge clk);
        #0.5;
        check_all("R9 held in reset with clock");
        rst_n = 1'b1;
        step(25'h1FFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R9 gated after release");
        step(25'h1FFFFFE, 1'b0, 1'b0, 1'b1, 1'b1, "R9 still zero data");

        // Random mix: gate_en tied low half the time (R8), shapes switch rarely.
        nar = 1'b0; alt = 1'b0;
        for (int k = 0; k < 600; k++) begin
            d = W'($urandom());
            if ($urandom_range(15) == 0) nar = 1'($urandom());
            if ($urandom_range(15) == 0) alt = 1'($urandom());
            gc = 1'($urandom());
            ge = (k < 300) ? 1'b0 : 1'($urandom());
            if (gc && ge)  tag = "R6 R7 random gated";
            else if (!nar) tag = "R1 R8 random wide";
            else if (!alt) tag = "R2 R8 random lower";
            else           tag = "R3 R8 random upper";
            step(d, nar, alt, gc, ge, tag);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule